// File: doc/BRIEF.md
# Segmented Burst Store-and-Forward Buffer

This block sits between the source datapath and the destination datapath of a DMA engine and holds whole bursts in one block RAM. The RAM is cut into a fixed number of equal segments, each as large as the longest burst, and every burst takes one segment of its own. A short burst leaves the tail of its segment empty, and the next burst starts in the next segment. Flow control is counted in bursts: the source may write while a segment is free, and the destination sees data only once a burst has been written completely.

The source side writes beats with a valid/ready handshake and an end-of-burst flag. The destination side reads the stored bursts in order with valid/ready and a last flag. When the two sides have different widths, related by a power of two, the block converts between them. Narrow source beats are packed into the wide memory word, lowest lane first, and a partly filled final word is written out with its last flag. A wide memory word is split into narrow destination beats, lowest lane first. The memory read takes one cycle, and its registered output holds the destination data steady while the destination stalls.

Top module: `sfb_burst_buffer`

## Requirements
- R1: While reset is high and in the first cycle after it, `src_ready` is 1 and `dst_valid` is 0.
- R2: Each burst takes exactly one segment, whatever its length. With the destination stalled, SEGMENTS single-beat bursts make `src_ready` fall.
- R3: `src_ready` is 0 while SEGMENTS finished bursts are stored and not yet drained. It returns to 1 in the cycle right after the destination handshake that carries `dst_last`.
- R4: `dst_valid` stays 0 while the only stored burst has not yet received its final source beat. It is 1 only while at least one complete burst is stored.
- R5: Bursts leave in the order they were written, with every data bit intact.
- R6: `dst_last` is 1 on the final destination beat of each burst and 0 on every other beat.
- R7: Up-sizing (SRC_W < DST_W): source beat k of a burst lands in lane k mod (DST_W/SRC_W) of its output word, where lane j occupies bits [j*SRC_W +: SRC_W]. A burst of n beats gives ceil(n*SRC_W/DST_W) output beats, and the unused lanes of a partial final word read as zero.
- R8: Down-sizing (SRC_W > DST_W): each source word gives SRC_W/DST_W destination beats, low lane (bits [DST_W-1:0]) first. `dst_last` is set only on the top lane of the final word.
- R9: While `dst_valid` is 1 and `dst_ready` is 0, `dst_valid`, `dst_data` and `dst_last` keep their values on the next cycle.
- R10: When a burst commits on the source side in the same cycle that a burst is released on the destination side, the occupancy stays unchanged, so `src_ready` keeps its value.
- R11: Bursts of the full BURST_BYTES length fill every segment without spilling into the next one, and all of them are read back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Source beat valid |
| src_ready | output | 1 | A segment is free for the source |
| src_data | input | SRC_W | Source beat data |
| src_last | input | 1 | Final beat of the source burst |
| dst_valid | output | 1 | Destination beat valid |
| dst_ready | input | 1 | Destination accepts the beat |
| dst_data | output | DST_W | Destination beat data |
| dst_last | output | 1 | Final beat of the stored burst |

## Verification
Two events can fall in the same clock edge: the source committing a burst (its last beat accepted) and the destination releasing one (its last beat accepted). Both move the occupancy that drives `src_ready`. The bench fills three of four segments with the destination stalled, then in one cycle presents a single-beat source burst and raises `dst_ready` while a one-word burst is shown. It then expects `src_ready` to stay high afterwards and to fall after exactly one more burst. The bench also checks that the released burst's data was the oldest one stored.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    // Index width that never collapses to zero bits.
    function automatic int bits_for(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    function automatic int wider(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Number of narrow lanes in one memory word.
    function automatic int lanes(input int mem_w, input int side_w);
        return mem_w / side_w;
    endfunction

endpackage

// File: rtl/sfb_pack.sv
module sfb_pack
    import sfb_pkg::*;
#(
    parameter int SRC_W = 16,
    parameter int MEM_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_fire,
    input  logic [SRC_W-1:0] in_data,
    input  logic             in_last,
    output logic             wr_en,
    output logic [MEM_W-1:0] wr_data,
    output logic             wr_last
);
    localparam int NL = lanes(MEM_W, SRC_W);
    localparam int LW = bits_for(NL);

    logic [LW-1:0]    lane;
    logic [MEM_W-1:0] acc;
    logic             lane_top;

    assign lane_top = (lane == LW'(NL - 1));

    // Current beat merged into the partly filled word, lowest lane first.
    always_comb begin
        wr_data = acc | (MEM_W'(in_data) << (lane * SRC_W));
        wr_en   = in_fire && (lane_top || in_last);
        wr_last = in_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane <= '0;
            acc  <= '0;
        end else if (in_fire) begin
            if (wr_en) begin
                lane <= '0;
                acc  <= '0;
            end else begin
                lane <= lane + 1'b1;
                acc  <= wr_data;
            end
        end
    end

endmodule

// File: rtl/sfb_store.sv
module sfb_store
    import sfb_pkg::*;
#(
    parameter int MEM_W    = 32,
    parameter int SEGMENTS = 4,
    parameter int DEPTH    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [MEM_W-1:0] wr_data,
    input  logic             wr_last,
    output logic             has_room,
    input  logic             q_take,
    output logic             q_valid,
    output logic [MEM_W-1:0] q_data,
    output logic             q_last
);
    localparam int SW   = bits_for(SEGMENTS);
    localparam int IW   = bits_for(DEPTH);
    localparam int PW   = SW + 1;
    localparam int ROWS = SEGMENTS << IW;

    logic [MEM_W-1:0] mem [ROWS];
    logic [IW-1:0]    last_idx [SEGMENTS];

    logic [PW-1:0] wptr, rptr, fptr;   // write, read-issue, free pointers
    logic [IW-1:0] widx, ridx;
    logic [SW-1:0] wseg, rseg;
    logic          adv, can_issue, issue, rd_final;

    assign wseg      = wptr[SW-1:0];
    assign rseg      = rptr[SW-1:0];
    assign has_room  = (wptr - fptr) != PW'(SEGMENTS);
    assign adv       = !q_valid || q_take;
    assign can_issue = (rptr != wptr);
    assign issue     = adv && can_issue;
    assign rd_final  = (ridx == last_idx[rseg]);

    // Datapath storage, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wseg, widx}] <= wr_data;
            if (wr_last)
                last_idx[wseg] <= widx;
        end
        if (issue)
            q_data <= mem[{rseg, ridx}];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            fptr    <= '0;
            widx    <= '0;
            ridx    <= '0;
            q_valid <= 1'b0;
            q_last  <= 1'b0;
        end else begin
            if (wr_en) begin
                if (wr_last) begin
                    widx <= '0;
                    wptr <= wptr + 1'b1;
                end else begin
                    widx <= widx + 1'b1;
                end
            end
            if (adv)
                q_valid <= can_issue;
            if (issue) begin
                q_last <= rd_final;
                if (rd_final) begin
                    ridx <= '0;
                    rptr <= rptr + 1'b1;
                end else begin
                    ridx <= ridx + 1'b1;
                end
            end
            if (q_take && q_last)
                fptr <= fptr + 1'b1;
        end
    end

endmodule

// File: rtl/sfb_unpack.sv
module sfb_unpack
    import sfb_pkg::*;
#(
    parameter int MEM_W = 32,
    parameter int DST_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             q_valid,
    input  logic [MEM_W-1:0] q_data,
    input  logic             q_last,
    output logic             q_take,
    input  logic             dst_ready,
    output logic             dst_valid,
    output logic [DST_W-1:0] dst_data,
    output logic             dst_last
);
    localparam int NL = lanes(MEM_W, DST_W);
    localparam int LW = bits_for(NL);

    logic [LW-1:0] lane;
    logic          lane_top;
    logic          fire;

    assign lane_top  = (lane == LW'(NL - 1));
    assign fire      = q_valid && dst_ready;
    assign dst_valid = q_valid;
    assign dst_data  = q_data[lane * DST_W +: DST_W];
    assign dst_last  = q_last && lane_top;
    assign q_take    = fire && lane_top;

    always_ff @(posedge clk) begin
        if (rst)
            lane <= '0;
        else if (fire)
            lane <= lane_top ? '0 : lane + 1'b1;
    end

endmodule

// File: rtl/sfb_burst_buffer.sv
module sfb_burst_buffer
    import sfb_pkg::*;
#(
    parameter int SRC_W       = 16,
    parameter int DST_W       = 32,
    parameter int SEGMENTS    = 4,
    parameter int BURST_BYTES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_valid,
    output logic             src_ready,
    input  logic [SRC_W-1:0] src_data,
    input  logic             src_last,
    output logic             dst_valid,
    input  logic             dst_ready,
    output logic [DST_W-1:0] dst_data,
    output logic             dst_last
);
    localparam int MEM_W = wider(SRC_W, DST_W);
    localparam int DEPTH = (BURST_BYTES * 8) / MEM_W;

    logic             wr_en, wr_last, has_room;
    logic [MEM_W-1:0] wr_data;
    logic             q_take, q_valid, q_last;
    logic [MEM_W-1:0] q_data;

    assign src_ready = has_room;

    sfb_pack #(.SRC_W(SRC_W), .MEM_W(MEM_W)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .in_fire (src_valid && has_room),
        .in_data (src_data),
        .in_last (src_last),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_last (wr_last)
    );

    sfb_store #(.MEM_W(MEM_W), .SEGMENTS(SEGMENTS), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_last  (wr_last),
        .has_room (has_room),
        .q_take   (q_take),
        .q_valid  (q_valid),
        .q_data   (q_data),
        .q_last   (q_last)
    );

    sfb_unpack #(.MEM_W(MEM_W), .DST_W(DST_W)) u_unpack (
        .clk       (clk),
        .rst       (rst),
        .q_valid   (q_valid),
        .q_data    (q_data),
        .q_last    (q_last),
        .q_take    (q_take),
        .dst_ready (dst_ready),
        .dst_valid (dst_valid),
        .dst_data  (dst_data),
        .dst_last  (dst_last)
    );

endmodule

// File: rtl/sfb_burst_buffer_chk.sv
module sfb_burst_buffer_chk #(
    parameter int SEGMENTS = 4,
    parameter int DST_W    = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             src_valid,
    input logic             src_ready,
    input logic             src_last,
    input logic             dst_valid,
    input logic             dst_ready,
    input logic [DST_W-1:0] dst_data,
    input logic             dst_last
);
    localparam int OW = $clog2(SEGMENTS) + 2;

    // Occupancy rebuilt from port handshakes only.
    logic [OW-1:0] occ;
    logic          commit, release_b;

    assign commit    = src_valid && src_ready && src_last;
    assign release_b = dst_valid && dst_ready && dst_last;

    always_ff @(posedge clk) begin
        if (rst)
            occ <= '0;
        else
            occ <= occ + OW'(commit) - OW'(release_b);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !dst_valid);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        dst_valid && !dst_ready |=> dst_valid && $stable(dst_data) && $stable(dst_last));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= OW'(SEGMENTS));

    // R3 R10
    ready_room_chk: assert property (@(posedge clk) disable iff (rst)
        src_ready == (occ < OW'(SEGMENTS)));

    // R4
    present_needs_burst_chk: assert property (@(posedge clk) disable iff (rst)
        dst_valid |-> occ != '0);

endmodule

bind sfb_burst_buffer sfb_burst_buffer_chk #(.SEGMENTS(SEGMENTS), .DST_W(DST_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_last  (src_last),
    .dst_valid (dst_valid),
    .dst_ready (dst_ready),
    .dst_data  (dst_data),
    .dst_last  (dst_last)
);

// File: tb/sim_sfb_burst_buffer.sv
module sim_sfb_burst_buffer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    // u0: up-sizing 16 -> 32
    logic        src0_valid = 1'b0, src0_last = 1'b0, dst0_ready = 1'b0;
    logic [15:0] src0_data  = '0;
    logic        src0_ready, dst0_valid, dst0_last;
    logic [31:0] dst0_data;

    // u1: down-sizing 32 -> 16
    logic        src1_valid = 1'b0, src1_last = 1'b0, dst1_ready = 1'b0;
    logic [31:0] src1_data  = '0;
    logic        src1_ready, dst1_valid, dst1_last;
    logic [15:0] dst1_data;

    sfb_burst_buffer #(.SRC_W(16), .DST_W(32), .SEGMENTS(4), .BURST_BYTES(16)) u0 (
        .clk(clk), .rst(rst),
        .src_valid(src0_valid), .src_ready(src0_ready), .src_data(src0_data), .src_last(src0_last),
        .dst_valid(dst0_valid), .dst_ready(dst0_ready), .dst_data(dst0_data), .dst_last(dst0_last));

    sfb_burst_buffer #(.SRC_W(32), .DST_W(16), .SEGMENTS(4), .BURST_BYTES(16)) u1 (
        .clk(clk), .rst(rst),
        .src_valid(src1_valid), .src_ready(src1_ready), .src_data(src1_data), .src_last(src1_last),
        .dst_valid(dst1_valid), .dst_ready(dst1_ready), .dst_data(dst1_data), .dst_last(dst1_last));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [16:0] src0_q[$];
    logic [32:0] exp0[$];
    logic [32:0] src1_q[$];
    logic [16:0] exp1[$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Builds source beats and the packed words expected on u0 (R7).
    task automatic load0(input int n, input logic [15:0] base);
        logic [31:0] w = '0;
        for (int i = 0; i < n; i++) begin
            logic [15:0] d = base + 16'(i);
            src0_q.push_back({(i == n - 1), d});
            w[(i % 2) * 16 +: 16] = d;
            if ((i % 2 == 1) || (i == n - 1)) begin
                exp0.push_back({(i == n - 1), w});
                w = '0;
            end
        end
    endtask

    // Builds source words and the split beats expected on u1 (R8).
    task automatic load1(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            logic [31:0] d = base + 32'(i) * 32'h0001_0001;
            src1_q.push_back({(i == n - 1), d});
            exp1.push_back({1'b0, d[15:0]});
            exp1.push_back({(i == n - 1), d[31:16]});
        end
    endtask

    task automatic send0(input int k);
        for (int j = 0; j < k; j++) begin
            logic [16:0] it = src0_q.pop_front();
            src0_valid = 1'b1; src0_data = it[15:0]; src0_last = it[16];
            while (!src0_ready) @(negedge clk);
            @(negedge clk);
        end
        src0_valid = 1'b0; src0_last = 1'b0;
    endtask

    task automatic send1(input int k);
        for (int j = 0; j < k; j++) begin
            logic [32:0] it = src1_q.pop_front();
            src1_valid = 1'b1; src1_data = it[31:0]; src1_last = it[32];
            while (!src1_ready) @(negedge clk);
            @(negedge clk);
        end
        src1_valid = 1'b0; src1_last = 1'b0;
    endtask

    // Receives n beats; mode 1 inserts stalls and checks holding (R9).
    task automatic rx0(input int n, input int mode, input string req);
        int got = 0; int cyc = 0; bit hold = 1'b0; logic [31:0] hd = '0;
        while (got < n) begin
            dst0_ready = (mode == 0) || (cyc % 3 != 1);
            if (hold) chk(dst0_valid && dst0_data == hd, "R9 u0 hold", {31'd0, dst0_valid, dst0_data}, {32'd1, hd});
            hold = dst0_valid && !dst0_ready; hd = dst0_data;
            if (dst0_valid && dst0_ready) begin
                if (exp0.size() == 0) chk(1'b0, {req, " u0 extra beat"}, {31'd0, dst0_last, dst0_data}, 64'd0);
                else begin
                    logic [32:0] e = exp0.pop_front();
                    chk(dst0_data == e[31:0] && dst0_last == e[32], req, {31'd0, dst0_last, dst0_data}, {31'd0, e});
                end
                got++;
            end
            @(negedge clk); cyc++;
        end
        dst0_ready = 1'b0;
    endtask

    task automatic rx1(input int n, input int mode, input string req);
        int got = 0; int cyc = 0; bit hold = 1'b0; logic [15:0] hd = '0;
        while (got < n) begin
            dst1_ready = (mode == 0) || (cyc % 3 != 1);
            if (hold) chk(dst1_valid && dst1_data == hd, "R9 u1 hold", {47'd0, dst1_valid, dst1_data}, {48'd1, hd});
            hold = dst1_valid && !dst1_ready; hd = dst1_data;
            if (dst1_valid && dst1_ready) begin
                if (exp1.size() == 0) chk(1'b0, {req, " u1 extra beat"}, {47'd0, dst1_last, dst1_data}, 64'd0);
                else begin
                    logic [16:0] e = exp1.pop_front();
                    chk(dst1_data == e[15:0] && dst1_last == e[16], req, {47'd0, dst1_last, dst1_data}, {47'd0, e});
                end
                got++;
            end
            @(negedge clk); cyc++;
        end
        dst1_ready = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(src0_ready && !dst0_valid, "R1 u0 in reset", {62'd0, src0_ready, dst0_valid}, 64'h2);
        rst = 1'b0;
        @(negedge clk);
        chk(src0_ready && !dst0_valid, "R1 u0 after reset", {62'd0, src0_ready, dst0_valid}, 64'h2);
        chk(src1_ready && !dst1_valid, "R1 u1 after reset", {62'd0, src1_ready, dst1_valid}, 64'h2);
    endtask

    task automatic t_partial();
        load0(4, 16'hA000);
        send0(3);
        repeat (4) @(negedge clk);
        chk(!dst0_valid, "R4 incomplete burst hidden", {63'd0, dst0_valid}, 64'd0);
        fork
            send0(1);
            rx0(2, 0, "R5 R6 R7 even burst");
        join
    endtask

    task automatic t_odd_up();
        load0(5, 16'hB100);
        load0(1, 16'hC200);
        fork
            send0(6);
            rx0(4, 1, "R6 R7 partial word zero fill");
        join
    endtask

    task automatic t_fill();
        for (int b = 0; b < 4; b++) load0(1, 16'hD000 + 16'(b * 16));
        send0(4);
        repeat (2) @(negedge clk);
        chk(!src0_ready, "R2 four short bursts fill", {63'd0, src0_ready}, 64'd0);
        chk(dst0_valid, "R4 complete burst shown", {63'd0, dst0_valid}, 64'd1);
        repeat (3) @(negedge clk);
        chk(!src0_ready, "R3 stays full", {63'd0, src0_ready}, 64'd0);
        rx0(1, 0, "R5 oldest first");
        chk(src0_ready, "R3 room after release", {63'd0, src0_ready}, 64'd1);
        rx0(3, 1, "R5 drain order");
    endtask

    task automatic t_same_cycle();
        for (int b = 0; b < 3; b++) load0(1, 16'hE000 + 16'(b));
        send0(3);
        repeat (3) @(negedge clk);
        load0(1, 16'hE0F0);
        begin
            logic [16:0] it = src0_q.pop_front();
            logic [32:0] e  = exp0.pop_front();
            src0_valid = 1'b1; src0_data = it[15:0]; src0_last = it[16];
            dst0_ready = 1'b1;
            chk(src0_ready && dst0_valid, "R10 both sides armed", {62'd0, src0_ready, dst0_valid}, 64'h3);
            chk(dst0_data == e[31:0] && dst0_last == e[32], "R5 released burst", {31'd0, dst0_last, dst0_data}, {31'd0, e});
            @(negedge clk);
            src0_valid = 1'b0; src0_last = 1'b0; dst0_ready = 1'b0;
        end
        chk(src0_ready, "R10 occupancy unchanged", {63'd0, src0_ready}, 64'd1);
        load0(1, 16'hE0F1);
        send0(1);
        chk(!src0_ready, "R10 one more burst fills", {63'd0, src0_ready}, 64'd0);
        rx0(4, 1, "R5 R6 after same-cycle");
    endtask

    task automatic t_down();
        load1(3, 32'h1111_0000);
        fork
            send1(3);
            rx1(6, 1, "R5 R6 R8 down-size");
        join
        load1(1, 32'h5A5A_C3C3);
        fork
            send1(1);
            rx1(2, 0, "R8 single word");
        join
    endtask

    task automatic t_max_len();
        for (int b = 0; b < 4; b++) load0(8, 16'h7000 + 16'(b * 256));
        send0(32);
        @(negedge clk);
        chk(!src0_ready, "R11 R2 max bursts fill", {63'd0, src0_ready}, 64'd0);
        rx0(16, 1, "R11 max length u0");
        for (int b = 0; b < 4; b++) load1(4, 32'h2000_0000 + 32'(b * 64));
        send1(16);
        @(negedge clk);
        chk(!src1_ready, "R11 R2 max bursts fill u1", {63'd0, src1_ready}, 64'd0);
        rx1(32, 1, "R11 R8 max length u1");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_partial();
        t_odd_up();
        t_fill();
        t_same_cycle();
        t_down();
        t_max_len();
        repeat (4) @(negedge clk);
        chk(exp0.size() == 0 && exp1.size() == 0, "R5 nothing left over",
            64'(exp0.size() + exp1.size()), 64'd0);
        wrap_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        wrap_up();
    end

endmodule